// File: doc/BRIEF.md
# Real-Time Clock Three-Wire Serial Port

This block is the serial front end of a real-time clock. An external host drives a chip-enable line, a serial clock and a data line. The block samples all three with the fast system clock and finds serial clock edges on the synchronised copies. On the first rising serial clock edge of a frame, the level on the data line chooses the direction of the frame.

In a read frame, the block copies the calendar core's time vector into a shift register and sends the vector out LSB first. It also drives the enable for the data pad. In a write frame, it shifts the incoming payload into a register and raises a commit strobe toward the calendar core, but only when a complete frame has arrived.

The block also drives three other signals toward the core:
- a freeze level that holds the counters still while a write is in progress;
- a strobe that clears the supply-fail flag after a sufficiently long read;
- a strobe that clears the factory test bit when chip-enable falls.

Top module: `rtc3w_port`

## Requirements
- R1: After reset, `sdio_oe`, `sdio_out`, `wr_commit`, `cnt_freeze`, `fail_clr` and `test_clr` are all 0.
- R2: With `ce_pin` high, the level of `sdio_in` at the first rising `sclk_pin` edge picks the frame type: 0 selects read, 1 selects write. The frame type holds until `ce_pin` falls.
- R3: Edges 1 to 8 of a frame carry control bits. In a read, the time vector is captured on the 8th falling edge. Bit k of that vector (k = 0..51) appears on `sdio_out` after rising edge 9+k. The vector is laid out, from bit 0 upward, as second[7:0], minute[15:8], hour[23:16], weekday[27:24], day[35:28], month[43:36] and year[51:44].
- R4: A change of `time_snap` after the capture does not alter the bits sent in the current read frame.
- R5: After the 60th rising edge of a read frame, `sdio_out` keeps its last value (vector bit 51) whatever further edges arrive.
- R6: `sdio_oe` is 1 only in a read frame, from the 9th rising edge until `ce_pin` goes low. It is never 1 in a write frame.
- R7: In a write frame, the bit sampled on rising edge 9+k becomes bit k of `wr_data`. A single-cycle `wr_commit` pulse follows the 60th rising edge.
- R8: A write frame in which `ce_pin` falls before the 60th rising edge produces no `wr_commit`.
- R9: In a write frame, bits after the 60th rising edge are ignored. There is exactly one commit, and `wr_data` holds the first 52 payload bits.
- R10: `fail_clr` pulses once when a read frame reaches its 56th rising edge. A read frame of 55 or fewer edges gives no pulse.
- R11: `cnt_freeze` rises at the first falling edge of a write frame and stays high until `ce_pin` goes low. It is never set in a read frame.
- R12: `test_clr` pulses once on every falling edge of `ce_pin`.
- R13: While `ce_pin` is low, `sclk_pin` and `sdio_in` have no effect. No frame starts, `sdio_oe` stays 0 and no commit happens, and the next frame starts counting from its first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_pin | input | 1 | Chip-enable from the host |
| sclk_pin | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Data pad input |
| time_snap | input | 52 | Current time vector from the calendar core |
| sdio_out | output | 1 | Data pad output value |
| sdio_oe | output | 1 | Data pad output enable |
| wr_data | output | 52 | Received time vector |
| wr_commit | output | 1 | One-cycle strobe: load `wr_data` into the counters |
| cnt_freeze | output | 1 | Counters held still during a write |
| fail_clr | output | 1 | One-cycle strobe clearing the supply-fail flag |
| test_clr | output | 1 | One-cycle strobe clearing the test bit |

## Verification
Two pairs of events can coincide in a single cycle:
- A write commit and the end of the frame: chip-enable can drop just after the 60th edge.
- A change of the time vector and an active read shift: a one-second carry can land in the middle of a read frame.

The bench provokes the first pair by ending write frames at exactly 60 edges, and also at 40 and 64 edges. It judges the result by the commit count and the committed word. It provokes the second pair by changing `time_snap` at edge 20 of a read frame. The received vector must then still equal the value captured at edge 8.

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] day;
    logic [3:0] wday;
    logic [7:0] hour;
    logic [7:0] minute;
    logic [7:0] second;
  } rtc_time_t;

  localparam int PAY_W = $bits(rtc_time_t);

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_READ  = 2'd1,
    FR_WRITE = 2'd2
  } frame_mode_e;

  // Edge count (before increment) at which a rising edge moves a payload bit.
  function automatic logic is_payload_edge(input int edges_seen, input int ctrl_bits,
                                           input int last_edge);
    return (edges_seen >= ctrl_bits) && (edges_seen < last_edge);
  endfunction

  // Total edges of a full frame.
  function automatic int frame_edges(input int ctrl_bits, input int pay_bits);
    return ctrl_bits + pay_bits;
  endfunction

endpackage

// File: rtl/rtc3w_sync.sv
module rtc3w_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d[gi]};
      end
      assign q[gi] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/rtc3w_frame_ctrl.sv
module rtc3w_frame_ctrl
  import rtc3w_pkg::*;
#(
  parameter int CTRL_BITS   = 8,
  parameter int PAY_BITS    = 52,
  parameter int FAIL_CLR_AT = 56,
  localparam int LAST  = CTRL_BITS + PAY_BITS,
  localparam int CNT_W = $clog2(LAST + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_s,
  input  logic             sclk_s,
  input  logic             din_s,
  output frame_mode_e      mode,
  output logic [CNT_W-1:0] cnt,
  output logic             load_snap,
  output logic             shift_rd,
  output logic             shift_wr,
  output logic             oe,
  output logic             freeze,
  output logic             commit,
  output logic             fail_clr,
  output logic             test_clr
);
  localparam logic [CNT_W-1:0] C_SAT   = CNT_W'(LAST + 1);
  localparam logic [CNT_W-1:0] C_LAST  = CNT_W'(LAST);
  localparam logic [CNT_W-1:0] C_CTRL  = CNT_W'(CTRL_BITS);
  localparam logic [CNT_W-1:0] C_PRE   = CNT_W'(LAST - 1);
  localparam logic [CNT_W-1:0] C_FCPRE = CNT_W'(FAIL_CLR_AT - 1);
  localparam logic [CNT_W-1:0] C_FC    = CNT_W'(FAIL_CLR_AT);

  logic sclk_q, ce_q;
  logic clk_rise, clk_fall, ce_fall, pay_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ce_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      ce_q   <= ce_s;
    end
  end

  // Named internal events
  assign clk_rise = ce_s & sclk_s & ~sclk_q;
  assign clk_fall = ce_s & ~sclk_s & sclk_q;
  assign ce_fall  = ~ce_s & ce_q;
  assign pay_edge = is_payload_edge(int'(cnt), CTRL_BITS, LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      mode <= FR_IDLE;
    end else if (!ce_s) begin
      cnt  <= '0;
      mode <= FR_IDLE;
    end else if (clk_rise) begin
      if (cnt == '0) mode <= din_s ? FR_WRITE : FR_READ;
      if (cnt != C_SAT) cnt <= cnt + 1'b1;
    end
  end

  assign load_snap = clk_fall && (mode == FR_READ) && (cnt == C_CTRL);
  assign shift_rd  = clk_rise && (mode == FR_READ) && pay_edge;
  assign shift_wr  = clk_rise && (mode == FR_WRITE) && pay_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe       <= 1'b0;
      freeze   <= 1'b0;
      commit   <= 1'b0;
      fail_clr <= 1'b0;
      test_clr <= 1'b0;
    end else begin
      commit   <= clk_rise && (mode == FR_WRITE) && (cnt == C_PRE);
      fail_clr <= clk_rise && (mode == FR_READ) && (cnt == C_FCPRE);
      test_clr <= ce_fall;
      if (!ce_s) begin
        oe     <= 1'b0;
        freeze <= 1'b0;
      end else begin
        if (clk_rise && (mode == FR_READ) && (cnt == C_CTRL)) oe <= 1'b1;
        if (clk_fall && (mode == FR_WRITE)) freeze <= 1'b1;
      end
    end
  end

  AST_COMMIT_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (cnt == C_LAST) && (mode == FR_WRITE)); // R7
  AST_FAILCLR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    fail_clr |-> (cnt == C_FC) && (mode == FR_READ)); // R10
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> (mode == FR_READ) && (cnt > C_CTRL)); // R6
  AST_FREEZE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> (mode == FR_WRITE)); // R11
  AST_IDLE_WHEN_CE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> (cnt == '0) && !oe && !freeze); // R13
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit, fail_clr})); // R7
endmodule

// File: rtl/rtc3w_shifter.sv
module rtc3w_shifter #(
  parameter int PAY_BITS = 52
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PAY_BITS-1:0] snap_in,
  input  logic                load_snap,
  input  logic                shift_rd,
  input  logic                shift_wr,
  input  logic                din_s,
  output logic                dout,
  output logic [PAY_BITS-1:0] wr_word
);
  logic [PAY_BITS-1:0] rd_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sh <= '0;
      dout  <= 1'b0;
    end else if (load_snap) begin
      rd_sh <= snap_in;
    end else if (shift_rd) begin
      dout  <= rd_sh[0];
      rd_sh <= {1'b0, rd_sh[PAY_BITS-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wr_word <= '0;
    else if (shift_wr) wr_word <= {din_s, wr_word[PAY_BITS-1:1]};
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_rd && shift_wr) && !(load_snap && shift_rd)); // R2
  AST_WR_WORD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_wr |=> $stable(wr_word)); // R9
endmodule

// File: rtl/rtc3w_port.sv
module rtc3w_port
  import rtc3w_pkg::*;
#(
  parameter int CTRL_BITS   = 8,
  parameter int FAIL_CLR_AT = 56,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_pin,
  input  logic             sclk_pin,
  input  logic             sdio_in,
  input  logic [PAY_W-1:0] time_snap,
  output logic             sdio_out,
  output logic             sdio_oe,
  output logic [PAY_W-1:0] wr_data,
  output logic             wr_commit,
  output logic             cnt_freeze,
  output logic             fail_clr,
  output logic             test_clr
);
  localparam int LAST  = frame_edges(CTRL_BITS, PAY_W);
  localparam int CNT_W = $clog2(LAST + 2);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(LAST);

  logic [2:0]       pins_s;
  logic             ce_s, sclk_s, din_s;
  frame_mode_e      mode;
  logic [CNT_W-1:0] cnt;
  logic             load_snap, shift_rd, shift_wr;

  rtc3w_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ce_pin, sclk_pin, sdio_in}), .q(pins_s)
  );
  assign {ce_s, sclk_s, din_s} = pins_s;

  rtc3w_frame_ctrl #(.CTRL_BITS(CTRL_BITS), .PAY_BITS(PAY_W), .FAIL_CLR_AT(FAIL_CLR_AT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .sclk_s(sclk_s), .din_s(din_s),
    .mode(mode), .cnt(cnt), .load_snap(load_snap), .shift_rd(shift_rd),
    .shift_wr(shift_wr), .oe(sdio_oe), .freeze(cnt_freeze), .commit(wr_commit),
    .fail_clr(fail_clr), .test_clr(test_clr)
  );

  rtc3w_shifter #(.PAY_BITS(PAY_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .snap_in(time_snap), .load_snap(load_snap),
    .shift_rd(shift_rd), .shift_wr(shift_wr), .din_s(din_s),
    .dout(sdio_out), .wr_word(wr_data)
  );

  AST_OUT_HOLDS_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= C_LAST) |=> $stable(sdio_out)); // R5
  AST_COMMIT_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> $stable(wr_data)); // R9
endmodule

// File: tb/tb_rtc3w_port.sv
module tb_rtc3w_port;
  localparam int H = 10;
  localparam int PW = 52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_pin = 1'b0, sclk_pin = 1'b0, sdio_in = 1'b0;
  logic [PW-1:0] time_snap = '0;
  logic sdio_out, sdio_oe, wr_commit, cnt_freeze, fail_clr, test_clr;
  logic [PW-1:0] wr_data;

  always #4 clk = ~clk;

  rtc3w_port dut (
    .clk(clk), .rst_n(rst_n), .ce_pin(ce_pin), .sclk_pin(sclk_pin), .sdio_in(sdio_in),
    .time_snap(time_snap), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .wr_data(wr_data),
    .wr_commit(wr_commit), .cnt_freeze(cnt_freeze), .fail_clr(fail_clr), .test_clr(test_clr)
  );

  int n_chk = 0, n_fail = 0;
  int n_commit = 0, n_fclr = 0, n_tclr = 0;
  logic [PW-1:0] last_commit = '0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (wr_commit) begin n_commit++; last_commit = wr_data; end
    if (fail_clr) n_fclr++;
    if (test_clr) n_tclr++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One frame; results in outputs
  task automatic frame(input bit wr, input int nclk, input logic [PW-1:0] wdat,
                       input bit swap_mid, input logic [PW-1:0] swap_val,
                       output logic [PW-1:0] rdat, output bit hold_ok,
                       output bit oe_bad, output bit frz_bad);
    rdat = '0; hold_ok = 1'b1; oe_bad = 1'b0; frz_bad = 1'b0;
    ce_pin = 1'b1;
    wcyc(H);
    for (int k = 1; k <= nclk; k++) begin
      if (k == 1)                      sdio_in = wr;
      else if (wr && k >= 9 && k <= 60) sdio_in = wdat[k-9];
      else                              sdio_in = wr;
      wcyc(H);
      sclk_pin = 1'b1;
      wcyc(H);
      if (!wr && k >= 9 && k <= 60) rdat[k-9] = sdio_out;
      if (!wr && k > 60 && sdio_out !== rdat[PW-1]) hold_ok = 1'b0;
      if (wr) oe_bad |= sdio_oe;
      else if ((k < 9 && sdio_oe) || (k >= 9 && !sdio_oe)) oe_bad = 1'b1;
      if (!wr || k == 1) frz_bad |= cnt_freeze;
      if (swap_mid && k == 20) time_snap = swap_val;
      sclk_pin = 1'b0;
      wcyc(H);
      if (wr && !cnt_freeze) frz_bad = 1'b1;
    end
    ce_pin = 1'b0;
    wcyc(2 * H);
    if (sdio_oe || cnt_freeze) begin oe_bad |= sdio_oe; frz_bad |= cnt_freeze; end
  endtask

  task automatic t_reset;
    chk(!sdio_oe && !sdio_out && !wr_commit && !cnt_freeze && !fail_clr && !test_clr,
        "R1 reset outputs", {sdio_oe, sdio_out, wr_commit, cnt_freeze, fail_clr, test_clr}, 0);
  endtask

  task automatic t_read_full;
    logic [PW-1:0] r; bit h, ob, fb; int f0 = n_fclr, t0 = n_tclr;
    time_snap = 52'hA_5C3_1E7_2B94_D6;
    frame(1'b0, 60, '0, 1'b0, '0, r, h, ob, fb);
    chk(r == 52'hA_5C3_1E7_2B94_D6, "R3 read vector", r, 52'hA_5C3_1E7_2B94_D6);
    chk(!ob, "R6 read oe window", ob, 0);
    chk(n_fclr == f0 + 1, "R10 flag clear on 60-edge read", n_fclr - f0, 1);
    chk(n_tclr == t0 + 1, "R12 test clear on CE fall", n_tclr - t0, 1);
    chk(!fb, "R11 no freeze in read", fb, 0);
  endtask

  task automatic t_read_snapshot;
    logic [PW-1:0] r; bit h, ob, fb;
    time_snap = 52'h1_2345_6789_ABCD;
    frame(1'b0, 60, '0, 1'b1, 52'hF_EDCB_A987_6543, r, h, ob, fb);
    chk(r == 52'h1_2345_6789_ABCD, "R4 snapshot kept", r, 52'h1_2345_6789_ABCD);
  endtask

  task automatic t_read_hold;
    logic [PW-1:0] r; bit h, ob, fb;
    time_snap = 52'h8_0000_0000_0001;
    frame(1'b0, 66, '0, 1'b0, '0, r, h, ob, fb);
    chk(h && r[PW-1], "R5 output holds after edge 60", {h, r[PW-1]}, 2'b11);
    chk(r == 52'h8_0000_0000_0001, "R3 read vector long frame", r, 52'h8_0000_0000_0001);
  endtask

  task automatic t_read_short;
    logic [PW-1:0] r; bit h, ob, fb; int f0;
    time_snap = 52'h0_00F0_0F0F_F0F0;
    f0 = n_fclr;
    frame(1'b0, 55, '0, 1'b0, '0, r, h, ob, fb);
    chk(n_fclr == f0, "R10 55-edge read no clear", n_fclr - f0, 0);
    chk(r[35:0] == 36'h0_0F0F_F0F0 && r[27:24] == 4'hF, "R3 partial read to weekday", r[35:0], 36'h0_0F0F_F0F0);
    f0 = n_fclr;
    frame(1'b0, 56, '0, 1'b0, '0, r, h, ob, fb);
    chk(n_fclr == f0 + 1, "R10 56-edge read clears", n_fclr - f0, 1);
  endtask

  task automatic t_write_full;
    logic [PW-1:0] r; bit h, ob, fb; int c0 = n_commit;
    frame(1'b1, 60, 52'h3_C0DE_1234_5A5A, 1'b0, '0, r, h, ob, fb);
    chk(n_commit == c0 + 1, "R7 commit count", n_commit - c0, 1);
    chk(last_commit == 52'h3_C0DE_1234_5A5A, "R7 committed word", last_commit, 52'h3_C0DE_1234_5A5A);
    chk(!ob, "R2 R6 write never drives", ob, 0);
    chk(!fb, "R11 freeze during write", fb, 0);
  endtask

  task automatic t_write_short;
    logic [PW-1:0] r; bit h, ob, fb; int c0 = n_commit;
    frame(1'b1, 40, 52'hF_FFFF_FFFF_FFFF, 1'b0, '0, r, h, ob, fb);
    chk(n_commit == c0, "R8 short write discarded", n_commit - c0, 0);
    wcyc(4);
    chk(!cnt_freeze, "R11 freeze drops at CE low", cnt_freeze, 0);
  endtask

  task automatic t_write_long;
    logic [PW-1:0] r; bit h, ob, fb; int c0 = n_commit;
    frame(1'b1, 64, 52'h9_8765_4321_0FED, 1'b0, '0, r, h, ob, fb);
    chk(n_commit == c0 + 1, "R9 one commit for long write", n_commit - c0, 1);
    chk(last_commit == 52'h9_8765_4321_0FED && wr_data == 52'h9_8765_4321_0FED,
        "R9 extra bits ignored", wr_data, 52'h9_8765_4321_0FED);
  endtask

  task automatic t_ce_low;
    logic [PW-1:0] r; bit h, ob, fb; int c0 = n_commit; bit oe_any = 1'b0;
    sdio_in = 1'b1;
    for (int k = 0; k < 70; k++) begin
      wcyc(H); sclk_pin = 1'b1; wcyc(H); oe_any |= sdio_oe | cnt_freeze; sclk_pin = 1'b0;
    end
    wcyc(H);
    chk(n_commit == c0 && !oe_any, "R13 CE low ignores pins", {n_commit - c0, oe_any}, 0);
    time_snap = 52'h5_5555_AAAA_3C3C;
    frame(1'b0, 60, '0, 1'b0, '0, r, h, ob, fb);
    chk(r == 52'h5_5555_AAAA_3C3C && !ob, "R13 next frame starts fresh", r, 52'h5_5555_AAAA_3C3C);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wcyc(5);
    t_reset();
    rst_n = 1'b1;
    wcyc(5);
    t_reset();
    t_read_full();
    t_read_snapshot();
    t_read_hold();
    t_read_short();
    t_write_full();
    t_write_short();
    t_write_long();
    t_ce_low();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule